// File: doc/BRIEF.md
# Peripheral Enumeration Register Block

This block lets software find out, one entry at a time, which peripherals sit behind it. A fixed table arrives on constant input ports. Each entry gives an identifier, a base address, a region size, a first interrupt number, an interrupt count and a name of up to `NAME_MAX` bytes. A separate input says how many entries are populated. Software works through a 32-bit register window. Reading the operation register moves a cursor to the next entry that has not yet been reported. The field registers then return the data of the entry under the cursor.

A level interrupt tells software that entries are waiting. An initialise command raises it, and it drops once a walk runs off the end of the table. Writing a destination address to the name register starts a byte streamer. The streamer copies the current entry's name to memory through a write port with a valid/ready handshake, one byte per accepted beat.

Top module: `dev_enum_ctrl`

## Requirements
- R1: After reset `irq`, `err_flag` and `nm_valid` are low, the cursor is idle and no entry is marked as reported.
- R2: Writing 0x00 to offset 0x00 (initialise) clears all reported marks and idles the cursor. It sets `irq` to 1 exactly when `num_entries` is nonzero. `irq` rises only through this command.
- R3: A read of offset 0x00 first marks the current entry as reported, if the cursor is valid. The search then starts at the entry after the cursor, or at entry 0 when the cursor is idle. The cursor lands on the lowest-numbered unreported entry below `num_entries` at or after that start, and the read returns 0x08.
- R4: When an offset 0x00 read finds no such entry, it returns 0x00, idles the cursor and drives `irq` low.
- R5: The field registers are: 0x08 name length in bytes, 0x0C identifier, 0x10 base address, 0x14 region size, 0x18 first interrupt and 0x1C interrupt count. Each returns the field of the current entry, zero-extended, or 0 while the cursor is idle. Read data appears on `bus_rdata` in the cycle after the strobe and is 0 in any cycle that follows no read.
- R6: A write to offset 0x04 while the cursor is valid streams the current entry's name. Beat k carries address `bus_wdata + k` and the name byte k taken from `tbl_name[(e*NAME_MAX+k)*8 +: 8]`, where e is the entry number. Beats run for k from 0 up to the name length from `tbl_name_len` minus one. A zero-length name produces no beat.
- R7: An offset 0x04 write is ignored while the cursor is idle, and also while a transfer is still in progress.
- R8: While `nm_valid` is high and `nm_ready` is low, `nm_valid`, `nm_addr` and `nm_data` hold steady.
- R9: The following set `err_flag`, which stays set until reset: a read of any in-window offset other than 0x00 and 0x08 to 0x1C, a write to any in-window offset other than 0x00 and 0x04, and a write of a nonzero value to 0x00. Such an access returns 0 on a read and has no other effect.
- R10: An access whose address lies outside `WIN_BASE` to `WIN_BASE + WIN_SIZE - 1` has no effect, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register access address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, ignored when `bus_rd` is also high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| num_entries | input | CNT_W | Number of populated table entries |
| tbl_id | input | N_ENTRIES*32 | Identifiers, entry e at bits e*32 |
| tbl_base | input | N_ENTRIES*ADDR_W | Region base addresses |
| tbl_size | input | N_ENTRIES*32 | Region sizes |
| tbl_irq | input | N_ENTRIES*IRQ_W | First interrupt numbers |
| tbl_irq_cnt | input | N_ENTRIES*IRQ_W | Interrupt counts |
| tbl_name_len | input | N_ENTRIES*NLEN_W | Name lengths in bytes |
| tbl_name | input | N_ENTRIES*NAME_MAX*8 | Name bytes |
| irq | output | 1 | Level interrupt: unreported entries exist |
| err_flag | output | 1 | Sticky bad-access flag |
| nm_valid | output | 1 | Name byte write valid |
| nm_ready | input | 1 | Name byte write accepted |
| nm_addr | output | ADDR_W | Name byte destination address |
| nm_data | output | 8 | Name byte |

## Verification
The bench builds the block with `N_ENTRIES` = 4 and `NAME_MAX` = 4, keeping the default window and a 32-bit address. With four slots, every value of `num_entries` from 0 to 4 can be swept, and each walk is checked against an arithmetic model of the reported marks, the cursor and `irq`. The name lengths 0, 3, 1 and 4 cover the empty name and the full-length name. A stalling ready pattern exercises the handshake hold, and a second name write during a transfer exercises the busy case.

// File: rtl/enum_pkg.sv
package enum_pkg;

  typedef enum logic [3:0] {
    F_NONE, F_OP, F_NAME, F_NLEN, F_ID, F_BASE, F_SIZE, F_IRQ, F_IRQN
  } fld_e;

  localparam logic [31:0] OP_MORE  = 32'h0000_0008;
  localparam logic [31:0] OP_DONE  = 32'h0000_0000;
  localparam logic [31:0] CMD_INIT = 32'h0000_0000;

  function automatic fld_e decode_off(input logic [31:0] off);
    case (off)
      32'h00:  return F_OP;
      32'h04:  return F_NAME;
      32'h08:  return F_NLEN;
      32'h0C:  return F_ID;
      32'h10:  return F_BASE;
      32'h14:  return F_SIZE;
      32'h18:  return F_IRQ;
      32'h1C:  return F_IRQN;
      default: return F_NONE;
    endcase
  endfunction

  function automatic logic is_field(input fld_e f);
    return (f == F_NLEN) || (f == F_ID) || (f == F_BASE) ||
           (f == F_SIZE) || (f == F_IRQ) || (f == F_IRQN);
  endfunction

endpackage

// File: rtl/enum_cursor.sv
module enum_cursor #(
  parameter int N     = 4,
  parameter int CNT_W = 3,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             init,
  input  logic [CNT_W-1:0] num,
  output logic             cur_valid,
  output logic [IDX_W-1:0] cur_idx,
  output logic             step_hit,
  output logic             irq
);

  logic [N-1:0]   rep;
  logic [N-1:0]   rep_m;
  logic [IDX_W:0] sk;
  int             start;

  // lowest unreported populated entry at or after start; MSB = found
  function automatic logic [IDX_W:0] seek(input logic [N-1:0] r,
                                          input int st, input int n);
    logic [IDX_W:0] res;
    res = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (j >= st && j < n && !r[j]) res = {1'b1, IDX_W'(j)};
    end
    return res;
  endfunction

  always_comb begin
    rep_m = rep;
    if (cur_valid) rep_m[cur_idx] = 1'b1;
    start    = cur_valid ? int'(cur_idx) + 1 : 0;
    sk       = seek(rep_m, start, int'(num));
    step_hit = sk[IDX_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep       <= '0;
      cur_valid <= 1'b0;
      cur_idx   <= '0;
      irq       <= 1'b0;
    end else if (init) begin
      rep       <= '0;
      cur_valid <= 1'b0;
      irq       <= (num != '0);
    end else if (step) begin
      rep       <= rep_m;
      cur_valid <= sk[IDX_W];
      if (sk[IDX_W]) cur_idx <= sk[IDX_W-1:0];
      else           irq     <= 1'b0;
    end
  end

endmodule

// File: rtl/enum_namexfer.sv
module enum_namexfer #(
  parameter int N        = 4,
  parameter int NAME_MAX = 4,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 2,
  parameter int NLEN_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [IDX_W-1:0]        start_idx,
  input  logic [ADDR_W-1:0]       start_addr,
  input  logic [N*NLEN_W-1:0]     tbl_name_len,
  input  logic [N*NAME_MAX*8-1:0] tbl_name,
  output logic                    busy,
  output logic                    nm_valid,
  input  logic                    nm_ready,
  output logic [ADDR_W-1:0]       nm_addr,
  output logic [7:0]              nm_data
);

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base;
  logic [NLEN_W-1:0] pos;
  logic [NLEN_W-1:0] len;
  logic [NLEN_W-1:0] start_len;

  function automatic logic [NLEN_W-1:0] len_of(input logic [N*NLEN_W-1:0] t,
                                               input int e);
    logic [NLEN_W-1:0] l;
    l = t[e*NLEN_W +: NLEN_W];
    if (int'(l) > NAME_MAX) l = NLEN_W'(NAME_MAX);
    return l;
  endfunction

  function automatic int byte_pos(input int e, input int k);
    return (e * NAME_MAX + k) * 8;
  endfunction

  assign start_len = len_of(tbl_name_len, int'(start_idx));
  assign nm_valid  = busy;
  assign nm_addr   = base + ADDR_W'(pos);

  always_comb begin
    nm_data = 8'h00;
    if (busy && int'(pos) < NAME_MAX)
      nm_data = tbl_name[byte_pos(int'(idx), int'(pos)) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      base <= '0;
      pos  <= '0;
      len  <= '0;
    end else if (!busy) begin
      if (start && start_len != '0) begin
        busy <= 1'b1;
        idx  <= start_idx;
        base <= start_addr;
        pos  <= '0;
        len  <= start_len;
      end
    end else if (nm_ready) begin
      pos <= pos + 1'b1;
      if (pos + 1'b1 == len) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/dev_enum_ctrl.sv
module dev_enum_ctrl
  import enum_pkg::*;
#(
  parameter int                N_ENTRIES = 4,
  parameter int                NAME_MAX  = 4,
  parameter int                ADDR_W    = 32,
  parameter int                IRQ_W     = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h1000_1000,
  parameter int                WIN_SIZE  = 32'h1000,
  localparam int               CNT_W     = $clog2(N_ENTRIES + 1),
  localparam int               NLEN_W    = $clog2(NAME_MAX + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic                            bus_rd,
  input  logic                            bus_wr,
  input  logic [31:0]                     bus_wdata,
  output logic [31:0]                     bus_rdata,
  input  logic [CNT_W-1:0]                num_entries,
  input  logic [N_ENTRIES*32-1:0]         tbl_id,
  input  logic [N_ENTRIES*ADDR_W-1:0]     tbl_base,
  input  logic [N_ENTRIES*32-1:0]         tbl_size,
  input  logic [N_ENTRIES*IRQ_W-1:0]      tbl_irq,
  input  logic [N_ENTRIES*IRQ_W-1:0]      tbl_irq_cnt,
  input  logic [N_ENTRIES*NLEN_W-1:0]     tbl_name_len,
  input  logic [N_ENTRIES*NAME_MAX*8-1:0] tbl_name,
  output logic                            irq,
  output logic                            err_flag,
  output logic                            nm_valid,
  input  logic                            nm_ready,
  output logic [ADDR_W-1:0]               nm_addr,
  output logic [7:0]                      nm_data
);

  localparam int IDX_W  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int WIN_AW = $clog2(WIN_SIZE);

  logic              win_hit;
  logic [WIN_AW-1:0] off;
  fld_e              fld;
  logic              rd_act, wr_act;
  logic              ev_op_rd, ev_field_rd, ev_bad_rd;
  logic              ev_init, ev_name_wr, ev_bad_wr;
  logic              cur_valid, step_hit, xfer_busy, num_nonzero;
  logic [IDX_W-1:0]  cur_idx;
  logic [31:0]       fval;

  assign win_hit = (bus_addr[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
  assign off     = bus_addr[WIN_AW-1:0];
  assign fld     = decode_off(32'(off));
  assign rd_act  = bus_rd && win_hit;
  assign wr_act  = bus_wr && !bus_rd && win_hit;

  assign ev_op_rd    = rd_act && (fld == F_OP);
  assign ev_field_rd = rd_act && is_field(fld);
  assign ev_bad_rd   = rd_act && !ev_op_rd && !ev_field_rd;
  assign ev_init     = wr_act && (fld == F_OP) && (bus_wdata == CMD_INIT);
  assign ev_name_wr  = wr_act && (fld == F_NAME);
  assign ev_bad_wr   = wr_act && !ev_init && !ev_name_wr;
  assign num_nonzero = (num_entries != '0);

  enum_cursor #(.N(N_ENTRIES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (ev_op_rd),
    .init      (ev_init),
    .num       (num_entries),
    .cur_valid (cur_valid),
    .cur_idx   (cur_idx),
    .step_hit  (step_hit),
    .irq       (irq)
  );

  enum_namexfer #(
    .N(N_ENTRIES), .NAME_MAX(NAME_MAX), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .NLEN_W(NLEN_W)
  ) u_xfer (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (ev_name_wr && cur_valid),
    .start_idx    (cur_idx),
    .start_addr   (ADDR_W'(bus_wdata)),
    .tbl_name_len (tbl_name_len),
    .tbl_name     (tbl_name),
    .busy         (xfer_busy),
    .nm_valid     (nm_valid),
    .nm_ready     (nm_ready),
    .nm_addr      (nm_addr),
    .nm_data      (nm_data)
  );

  always_comb begin
    int e;
    e = int'(cur_idx);
    case (fld)
      F_NLEN:  fval = 32'(tbl_name_len[e*NLEN_W +: NLEN_W]);
      F_ID:    fval = tbl_id[e*32 +: 32];
      F_BASE:  fval = 32'(tbl_base[e*ADDR_W +: ADDR_W]);
      F_SIZE:  fval = tbl_size[e*32 +: 32];
      F_IRQ:   fval = 32'(tbl_irq[e*IRQ_W +: IRQ_W]);
      F_IRQN:  fval = 32'(tbl_irq_cnt[e*IRQ_W +: IRQ_W]);
      default: fval = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= 32'h0;
      err_flag  <= 1'b0;
    end else begin
      if (ev_op_rd)         bus_rdata <= step_hit ? OP_MORE : OP_DONE;
      else if (ev_field_rd) bus_rdata <= cur_valid ? fval : 32'h0;
      else                  bus_rdata <= 32'h0;
      if (ev_bad_rd || ev_bad_wr) err_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/enum_checker.sv
module enum_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_op_rd,
  input logic              ev_init,
  input logic              ev_field_rd,
  input logic              cur_valid,
  input logic              num_nonzero,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              err_flag,
  input logic              nm_valid,
  input logic              nm_ready,
  input logic [ADDR_W-1:0] nm_addr,
  input logic [7:0]        nm_data
);

  AST_OP_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_op_rd |=> (bus_rdata == 32'h0 || bus_rdata == 32'h8)); // R3

  AST_DONE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_op_rd ##1 bus_rdata == 32'h0) |-> !irq); // R4

  AST_INIT_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ev_init |=> (irq == $past(num_nonzero))); // R2

  AST_IRQ_RISE_BY_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_init)); // R2

  AST_IDLE_FIELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_field_rd && !cur_valid) |=> (bus_rdata == 32'h0)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R9

  AST_NAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nm_valid && !nm_ready) |=>
      (nm_valid && $stable(nm_addr) && $stable(nm_data))); // R8

endmodule

bind dev_enum_ctrl enum_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_op_rd    (ev_op_rd),
  .ev_init     (ev_init),
  .ev_field_rd (ev_field_rd),
  .cur_valid   (cur_valid),
  .num_nonzero (num_nonzero),
  .bus_rdata   (bus_rdata),
  .irq         (irq),
  .err_flag    (err_flag),
  .nm_valid    (nm_valid),
  .nm_ready    (nm_ready),
  .nm_addr     (nm_addr),
  .nm_data     (nm_data)
);

// File: tb/test_dev_enum_ctrl.sv
module test_dev_enum_ctrl;

  localparam int N  = 4;
  localparam int NM = 4;
  localparam logic [31:0] WB = 32'h1000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0] num_entries = 3'd4;
  logic [N*32-1:0] tbl_id, tbl_size;
  logic [N*32-1:0] tbl_base;
  logic [N*8-1:0] tbl_irq, tbl_irq_cnt;
  logic [N*3-1:0] tbl_name_len;
  logic [N*NM*8-1:0] tbl_name;
  logic irq, err_flag, nm_valid;
  logic nm_ready = 1'b1;
  logic [31:0] nm_addr;
  logic [7:0] nm_data;

  int tests = 0, fails = 0;
  logic rdy_mode = 1'b0;
  int cyc = 0;
  logic [31:0] got_addr [16];
  logic [7:0]  got_data [16];
  int got_n = 0;

  // model state
  logic m_rep [N];
  logic m_valid = 1'b0;
  int   m_idx = 0;
  logic m_irq = 1'b0;

  always #10 clk = ~clk;

  dev_enum_ctrl #(.N_ENTRIES(N), .NAME_MAX(NM)) i_dev_enum_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .num_entries(num_entries), .tbl_id(tbl_id), .tbl_base(tbl_base),
    .tbl_size(tbl_size), .tbl_irq(tbl_irq), .tbl_irq_cnt(tbl_irq_cnt),
    .tbl_name_len(tbl_name_len), .tbl_name(tbl_name), .irq(irq),
    .err_flag(err_flag), .nm_valid(nm_valid), .nm_ready(nm_ready),
    .nm_addr(nm_addr), .nm_data(nm_data)
  );

  function automatic logic [31:0] f_id(int e);   return 32'hA0 + e; endfunction
  function automatic logic [31:0] f_base(int e); return 32'h2000_0000 + e * 32'h1000; endfunction
  function automatic logic [31:0] f_size(int e); return 32'h100 << e; endfunction
  function automatic logic [31:0] f_irq(int e);  return 5 + 2 * e; endfunction
  function automatic logic [31:0] f_cnt(int e);  return e + 1; endfunction
  function automatic logic [31:0] f_nlen(int e); return (e * 3) % 5; endfunction
  function automatic logic [7:0]  f_byte(int e, int k); return 8'(8'h40 + e * 16 + k); endfunction

  initial begin
    for (int e = 0; e < N; e++) begin
      tbl_id[e*32 +: 32]   = f_id(e);
      tbl_base[e*32 +: 32] = f_base(e);
      tbl_size[e*32 +: 32] = f_size(e);
      tbl_irq[e*8 +: 8]    = 8'(f_irq(e));
      tbl_irq_cnt[e*8 +: 8] = 8'(f_cnt(e));
      tbl_name_len[e*3 +: 3] = 3'(f_nlen(e));
      for (int k = 0; k < NM; k++) tbl_name[(e*NM+k)*8 +: 8] = f_byte(e, k);
    end
    for (int e = 0; e < N; e++) m_rep[e] = 1'b0;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    nm_ready <= rdy_mode ? (cyc % 3 != 0) : 1'b1;
  end

  always @(posedge clk) begin
    if (nm_valid && nm_ready && got_n < 16) begin
      got_addr[got_n] <= nm_addr;
      got_data[got_n] <= nm_data;
      got_n <= got_n + 1;
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd_reg(logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr_reg(logic [31:0] a, logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic model_init();
    for (int e = 0; e < N; e++) m_rep[e] = 1'b0;
    m_valid = 1'b0;
    m_irq = (num_entries != 0);
  endtask

  task automatic model_op(output logic [31:0] ret);
    int st;
    int hit;
    if (m_valid) begin m_rep[m_idx] = 1'b1; st = m_idx + 1; end
    else st = 0;
    hit = -1;
    for (int j = N - 1; j >= 0; j--)
      if (j >= st && j < int'(num_entries) && !m_rep[j]) hit = j;
    if (hit >= 0) begin m_valid = 1'b1; m_idx = hit; ret = 32'h8; end
    else begin m_valid = 1'b0; m_irq = 1'b0; ret = 32'h0; end
  endtask

  function automatic logic [31:0] exp_field(int o);
    if (!m_valid) return 0;
    case (o)
      8'h08: return f_nlen(m_idx);
      8'h0C: return f_id(m_idx);
      8'h10: return f_base(m_idx);
      8'h14: return f_size(m_idx);
      8'h18: return f_irq(m_idx);
      default: return f_cnt(m_idx);
    endcase
  endfunction

  task automatic op_step(string tag);
    logic [31:0] d, e;
    rd_reg(WB, d);
    model_op(e);
    check(e == 0 ? "R4 op done" : {"R3 op ", tag}, d, e);
    check("R4 irq after op", 32'(irq), 32'(m_irq));
  endtask

  task automatic check_fields();
    logic [31:0] d;
    for (int o = 8; o <= 8'h1C; o += 4) begin
      rd_reg(WB + o, d);
      check("R5 field", d, exp_field(o));
    end
  endtask

  task automatic do_init();
    wr_reg(WB, 32'h0);
    model_init();
    check("R2 init irq", 32'(irq), 32'(m_irq));
  endtask

  task automatic name_xfer(logic [31:0] a, int e, int n, string tag);
    got_n = 0;
    wr_reg(WB + 4, a);
    wr_reg(WB + 4, a + 32'h1000);
    repeat (30) @(negedge clk);
    check({tag, " count"}, got_n, n);
    for (int k = 0; k < n && k < got_n; k++) begin
      check({tag, " addr"}, got_addr[k], a + k);
      check({tag, " data"}, 32'(got_data[k]), 32'(f_byte(e, k)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 err", 32'(err_flag), 0);
    check("R1 nm_valid", 32'(nm_valid), 0);
    check_fields();
    // R3: op read before any init starts at entry 0, irq stays low
    op_step("pre-init");
    check_fields();

    // sweep all populations
    for (int n = 0; n <= N; n++) begin
      num_entries = 3'(n);
      do_init();
      check_fields();
      for (int k = 0; k < n + 2; k++) begin
        op_step("walk");
        check_fields();
      end
    end

    // R10: outside window, irq currently low after exhaustion
    wr_reg(WB + 32'h1000, 32'h0);
    check("R10 ignored init", 32'(irq), 0);
    rd_reg(WB - 4, d);
    check("R10 read zero", d, 0);
    check("R10 no error", 32'(err_flag), 0);

    // name transfers, num = 4, stalling ready
    rdy_mode = 1'b1;
    num_entries = 3'd4;
    do_init();
    name_xfer(32'h7000, 0, 0, "R7 idle name");
    op_step("e0");
    name_xfer(32'h7100, 0, 0, "R6 zero len");
    op_step("e1");
    name_xfer(32'h8000, 1, 3, "R6 R7 busy name");
    op_step("e2");
    name_xfer(32'h8800, 2, 1, "R6 name");
    op_step("e3");
    name_xfer(32'h9000, 3, 4, "R6 full name");
    rdy_mode = 1'b0;

    // R9 errors
    do_init();
    op_step("e0 again");
    rd_reg(WB + 4, d);
    check("R9 bad read data", d, 0);
    check("R9 err set", 32'(err_flag), 1);
    wr_reg(WB, 32'h3);
    check("R9 bad cmd irq", 32'(irq), 32'(m_irq));
    wr_reg(WB + 8'h10, 32'hFFFF);
    wr_reg(WB + 8'h40, 32'h1);
    check_fields();
    op_step("after errors");
    check("R9 err sticky", 32'(err_flag), 1);
    @(negedge clk);
    check("R5 idle rdata", bus_rdata, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule